// File: doc/BRIEF.md
# Cache Set LRU Replacement Tracker

This block keeps the usage history of the ways in one cache set, or of a whole fully-associative cache, and names the way to evict next. A set-associative cache places one instance per set. The history is an ordered list of way indices that runs from least recently used to most recently used. The entry at the least-recently-used end is the victim, and it is driven straight from a register onto `victim_way`.

The cache controller reports each lookup on the usage port. It raises `acc_req`, gives the hit way on `acc_way`, and sets `acc_inv` when the hit also invalidates the line. The `acc_wr` flag gives the direction of the access but has no effect on the history. When the controller fills a line, it raises `rep_req`. The way on `victim_way` is then counted as freshly used.

Every command takes effect on the rising clock edge. The new victim appears on the output in the following cycle.

Top module: `lru_set_tracker`

## Requirements
- R1: The parameter `NUM_WAYS` defaults to 32. `acc_way` and `victim_way` are each max(1, ceil(log2(NUM_WAYS))) bits wide, which is 5 bits at the default, so every way from 0 to 31 can be addressed.
- R2: A synchronous active-high `rst` loads the order 0, 1, …, NUM_WAYS-1, with way 0 least recently used. `victim_way` reads 0 in the cycle after reset.
- R3: When `acc_req` and `rep_req` are both low, the history does not change, whatever `acc_inv`, `acc_wr` and `acc_way` are.
- R4: With `acc_req`=1, `acc_inv`=0 and `rep_req`=0, way `acc_way` moves to the most-recently-used end. Ways that were more recent than it move one place toward the LRU end, and older ways keep their places. The result is the same for `acc_wr`=0 and `acc_wr`=1.
- R5: With `acc_req`=1, `acc_inv`=1 and `rep_req`=0, for either value of `acc_wr`, way `acc_way` moves to the least-recently-used end. `victim_way` shows that way in the next cycle.
- R6: With `rep_req`=1, `acc_req`=0 and `acc_inv`=0, the way on `victim_way` moves to the most-recently-used end. The next victim is the way that was second least recently used.
- R7: The combinations `acc_req`=1 with `rep_req`=1, and `rep_req`=1 with `acc_inv`=1, are illegal. Both leave the history unchanged.
- R8: The history always holds every way exactly once. As a result, NUM_WAYS back-to-back replace commands name each way on `victim_way` exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Usage update strobe for a tag hit |
| acc_wr | input | 1 | Access direction (1 = write); has no effect on the history |
| acc_inv | input | 1 | The hit also invalidates the line |
| acc_way | input | IDX_W | Way that was hit |
| rep_req | input | 1 | Replace strobe; the way on `victim_way` is refilled |
| victim_way | output | IDX_W | Registered index of the next way to evict |

## Verification
On every cycle, the assertions check the following:
- the history stays a permutation of the ways;
- a hit leaves its way at the most-recently-used end;
- an invalidate puts its way on the victim output;
- a replace moves the old victim to the most-recently-used end;
- idle and illegal cycles leave the history frozen.

The shifting of the ways in between is not checked by any single-cycle property. For example, a hit must preserve the relative order of the ways above the hit position. Only the bench's queue model shows this, because it follows the whole order through long mixed sequences of hits, invalidates and replaces and compares the victim every cycle. The full replace rotation and the reset order are likewise shown by the bench scenarios.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Decoded usage command for one clock cycle
    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_HIT     = 2'd1,
        CMD_INVAL   = 2'd2,
        CMD_REFILL  = 2'd3
    } lru_cmd_e;

    // Direction an entry is moved inside the order list
    typedef enum logic [1:0] {
        MOVE_HOLD   = 2'd0,
        MOVE_TO_MRU = 2'd1,
        MOVE_TO_LRU = 2'd2
    } lru_move_e;

    function automatic int idx_width(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/lru_cmd_decode.sv
module lru_cmd_decode
    import lru_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     acc_req,
    input  logic     acc_wr,
    input  logic     acc_inv,
    input  logic     rep_req,
    output lru_cmd_e cmd
);

    // direction of the access never affects the usage order
    logic unused_dir;
    assign unused_dir = acc_wr;

    always_comb begin
        cmd = CMD_NONE;
        if (acc_req && rep_req) begin
            cmd = CMD_NONE;
        end else if (acc_req) begin
            cmd = acc_inv ? CMD_INVAL : CMD_HIT;
        end else if (rep_req && !acc_inv) begin
            cmd = CMD_REFILL;
        end
    end

    // R7
    illegal_combo_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_req && rep_req) || (rep_req && acc_inv) |-> cmd == CMD_NONE);

endmodule

// File: rtl/lru_order_update.sv
module lru_order_update
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 32,
    parameter int IDX_W    = idx_width(NUM_WAYS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_WAYS-1:0][IDX_W-1:0]    order_in,
    input  logic [IDX_W-1:0]                  sel_way,
    input  lru_move_e                         move,
    output logic [NUM_WAYS-1:0][IDX_W-1:0]    order_out
);

    logic [NUM_WAYS-1:0] match;      // slot holds sel_way
    logic [NUM_WAYS-1:0] at_or_above; // slot index >= position of sel_way
    logic [NUM_WAYS-1:0] at_or_below; // slot index <= position of sel_way
    logic                found;

    logic [NUM_WAYS-1:0][IDX_W-1:0] promoted;
    logic [NUM_WAYS-1:0][IDX_W-1:0] demoted;

    always_comb begin
        for (int i = 0; i < NUM_WAYS; i++) begin
            match[i] = (order_in[i] == sel_way);
        end
        for (int i = 0; i < NUM_WAYS; i++) begin
            at_or_above[i] = 1'b0;
            at_or_below[i] = 1'b0;
            for (int j = 0; j < NUM_WAYS; j++) begin
                if (j <= i) at_or_above[i] = at_or_above[i] | match[j];
                if (j >= i) at_or_below[i] = at_or_below[i] | match[j];
            end
        end
        found = |match;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_slot
            if (g == NUM_WAYS - 1) begin : g_top
                assign promoted[g] = found ? sel_way : order_in[g];
            end else begin : g_mid_up
                assign promoted[g] = at_or_above[g] ? order_in[g+1] : order_in[g];
            end
            if (g == 0) begin : g_bottom
                assign demoted[g] = found ? sel_way : order_in[g];
            end else begin : g_mid_dn
                assign demoted[g] = (at_or_below[g] && !match[g]) || (match[g])
                                    ? order_in[g-1] : order_in[g];
            end
        end
    endgenerate

    always_comb begin
        unique case (move)
            MOVE_TO_MRU: order_out = promoted;
            MOVE_TO_LRU: order_out = demoted;
            default:     order_out = order_in;
        endcase
    end

    // R8: a present way is never lost by a move
    move_keeps_way_chk: assert property (@(posedge clk) disable iff (rst)
        found && move != MOVE_HOLD |-> $countones(match) == 1);

endmodule

// File: rtl/lru_set_tracker.sv
module lru_set_tracker
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 32,
    localparam int IDX_W   = idx_width(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_req,
    input  logic             acc_wr,
    input  logic             acc_inv,
    input  logic [IDX_W-1:0] acc_way,
    input  logic             rep_req,
    output logic [IDX_W-1:0] victim_way
);

    typedef struct packed {
        logic [NUM_WAYS-1:0][IDX_W-1:0] order; // [0] = LRU, [NUM_WAYS-1] = MRU
    } state_t;

    state_t    st_d, st_q;
    lru_cmd_e  cmd;
    lru_move_e move;
    logic [IDX_W-1:0]               sel_way;
    logic [NUM_WAYS-1:0][IDX_W-1:0] order_next;

    lru_cmd_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .acc_req (acc_req),
        .acc_wr  (acc_wr),
        .acc_inv (acc_inv),
        .rep_req (rep_req),
        .cmd     (cmd)
    );

    always_comb begin
        sel_way = acc_way;
        move    = MOVE_HOLD;
        unique case (cmd)
            CMD_HIT:    move = MOVE_TO_MRU;
            CMD_INVAL:  move = MOVE_TO_LRU;
            CMD_REFILL: begin
                move    = MOVE_TO_MRU;
                sel_way = st_q.order[0];
            end
            default:    move = MOVE_HOLD;
        endcase
    end

    lru_order_update #(
        .NUM_WAYS (NUM_WAYS),
        .IDX_W    (IDX_W)
    ) u_upd (
        .clk       (clk),
        .rst       (rst),
        .order_in  (st_q.order),
        .sel_way   (sel_way),
        .move      (move),
        .order_out (order_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.order = order_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                st_q.order[i] <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_way = st_q.order[0];

    // ---------------- assertions ----------------
    logic [NUM_WAYS-1:0] way_present;
    always_comb begin
        way_present = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (st_q.order[i] == IDX_W'(w)) way_present[w] = 1'b1;
            end
        end
    end

    // R2
    reset_victim_chk: assert property (@(posedge clk)
        rst |=> victim_way == '0);

    // R8
    permutation_chk: assert property (@(posedge clk) disable iff (rst)
        &way_present);

    // R3
    idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_req && !rep_req |=> $stable(st_q));

    // R7
    illegal_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_req && rep_req) || (!acc_req && rep_req && acc_inv) |=> $stable(st_q));

    // R4
    hit_to_mru_chk: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_inv && !rep_req && (int'(acc_way) < NUM_WAYS)
        |=> st_q.order[NUM_WAYS-1] == $past(acc_way));

    // R5
    inval_to_victim_chk: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_inv && !rep_req && (int'(acc_way) < NUM_WAYS)
        |=> victim_way == $past(acc_way));

    // R6
    refill_to_mru_chk: assert property (@(posedge clk) disable iff (rst)
        rep_req && !acc_req && !acc_inv
        |=> st_q.order[NUM_WAYS-1] == $past(victim_way));

endmodule

// File: tb/tb_lru_set_tracker.sv
`timescale 1ns/1ps
module tb_lru_set_tracker;

    localparam int WAYS = 32;
    localparam int IW   = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_req, acc_wr, acc_inv, rep_req;
    logic [IW-1:0] acc_way;
    logic [IW-1:0] victim_way;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int model[$];

    always #4 clk = ~clk; // 125 MHz

    lru_set_tracker #(.NUM_WAYS(WAYS)) dut (
        .clk        (clk),
        .rst        (rst),
        .acc_req    (acc_req),
        .acc_wr     (acc_wr),
        .acc_inv    (acc_inv),
        .acc_way    (acc_way),
        .rep_req    (rep_req),
        .victim_way (victim_way)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        model.delete();
        for (int i = 0; i < WAYS; i++) model.push_back(i);
    endtask

    function automatic int find_way(input int w);
        for (int i = 0; i < model.size(); i++) if (model[i] == w) return i;
        return -1;
    endfunction

    task automatic model_step(input bit a, input bit inv, input int w, input bit r);
        int p;
        if (a && r) return;              // illegal pair
        if (a) begin
            p = find_way(w);
            if (p < 0) return;
            model.delete(p);
            if (inv) model.push_front(w); else model.push_back(w);
        end else if (r && !inv) begin
            p = model[0];
            model.delete(0);
            model.push_back(p);
        end
    endtask

    // drive one cycle at negedge, compare victim at the following negedge
    task automatic step(input bit a, input bit wr, input bit inv, input int w,
                        input bit r, input string req);
        acc_req = a; acc_wr = wr; acc_inv = inv; acc_way = IW'(w); rep_req = r;
        @(posedge clk);
        model_step(a, inv, w, r);
        @(negedge clk);
        check(req, int'(victim_way), model[0]);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen[WAYS];
        rst = 1'b1; acc_req = 0; acc_wr = 0; acc_inv = 0; acc_way = '0; rep_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R2 reset victim", int'(victim_way), 0);

        // R3 idle with noisy side inputs
        step(0, 1, 1, 7, 0, "R3 idle");
        step(0, 0, 0, 3, 0, "R3 idle");

        // R4 hits: read and write, including highest way (R1)
        step(1, 0, 0, 0, 0, "R4 hit read lru");
        step(1, 1, 0, 1, 0, "R4 hit write");
        step(1, 0, 0, 31, 0, "R1 R4 hit top way");
        step(1, 1, 0, 5, 0, "R4 hit write mid");
        for (int i = 2; i < 10; i++) step(1, i % 2, 0, i, 0, "R4 hit sweep");

        // R5 invalidates, read and write flavours
        step(1, 0, 1, 20, 0, "R5 inval read");
        step(1, 1, 1, 31, 0, "R5 inval write");
        step(1, 0, 1, 31, 0, "R5 inval already lru");

        // R6 replaces
        step(0, 0, 0, 0, 1, "R6 replace");
        step(0, 0, 0, 0, 1, "R6 replace");

        // R7 illegal combinations
        step(1, 0, 0, 12, 1, "R7 access+replace");
        step(1, 1, 1, 12, 1, "R7 inval+replace");
        step(0, 0, 1, 12, 1, "R7 replace+inval");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            step(k < 5, $urandom_range(0, 1), k == 4 || k == 5,
                 $urandom_range(0, WAYS - 1), k >= 6, "R4 R5 R6 mixed");
        end

        // R8 rotation: each way named once over WAYS replaces
        for (int i = 0; i < WAYS; i++) seen[i] = 0;
        for (int i = 0; i < WAYS; i++) begin
            seen[int'(victim_way)]++;
            step(0, 0, 0, 0, 1, "R8 rotation");
        end
        for (int i = 0; i < WAYS; i++) check("R8 way seen once", seen[i], 1);

        // R2 reset in the middle of traffic
        acc_req = 1; acc_inv = 1; acc_way = IW'(17); rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; acc_req = 0; acc_inv = 0;
        model_reset();
        check("R2 reset mid run", int'(victim_way), 0);
        step(0, 0, 0, 0, 1, "R2 R6 order after reset");
        check("R2 second way", int'(victim_way), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule